// File: doc/BRIEF.md
# Interrupt Routing Register Window

This block is the register slave of an I/O interrupt controller. Software reaches every internal register through two byte offsets. It first writes a register number into a select register, then reads or writes the chosen register through a 32-bit data window. Behind the window sit a 4-bit controller identifier, a read-only version word, and a routing table with one 64-bit entry per interrupt pin. Each entry is reached as two 32-bit halves.

The routing table is driven out in parallel, so that the delivery logic can act on it. That logic owns two status bits in each entry. It reports delivery status on a level input. It sets and clears the remote-IRR flag through pulse inputs. Software writes never change these two bits. A write that leaves an entry in edge mode drops its remote-IRR flag.

Every table write sends a one-hot pulse that clears the storm counter of the written pin, together with a request for a new service pass. A 4-byte write to the end-of-interrupt offset is passed on as a vector pulse to an external handler. This only happens when the block is built with version 0x20.

Top module: `intr_route_regs`

## Requirements
- R1: After reset the select register and the identifier read 0. Every table entry reads 0x0001_0000 in its low half (only the mask bit, bit 16, is set) and 0 in its high half.
- R2: Only address bits 7:0 are decoded. Offset 0x00 holds the 8-bit select register, which is written from data bits 7:0 at any access size and read back zero-extended. Offset 0x10 is the data window and offset 0x40 is the end-of-interrupt port. Any other offset reads as 0.
- R3: A data-window access whose size is not 4 bytes returns 0 on a read and changes nothing on a write. Every read returns its data with `rd_valid` one cycle after the access.
- R4: Select value 1 reads as VERSION | ((PINS-1) << 16), which is 0x0017_0020 by default. Writes to it are ignored.
- R5: Select values 0 and 2 both read the identifier in bits 27:24. A window write with select 0 loads the identifier from data bits 27:24. A window write with select 2 is ignored.
- R6: A select value s from 0x10 up addresses table entry (s-0x10)>>1. An odd s addresses bits 63:32 and an even s addresses bits 31:0. A select value that maps to no entry (3 to 0x0F, or an index of PINS or more) reads 0 and ignores writes.
- R7: A table write stores only the writable bits: 11:0, 13, 15, 16 and 63:48. Bits 12 (delivery status, taken from `dstat`) and 14 (remote IRR) keep their values. All other bits read 0.
- R8: A table write that leaves bit 15 (trigger, 1 = level) at 0 clears the entry's remote-IRR bit.
- R9: In the cycle after a table write, `resvc_req` is 1 and `ctr_clr` has exactly the written pin's bit set. After any other access, or when there is no access, both are 0.
- R10: A 4-byte write to offset 0x40 with VERSION 0x20 gives a one-cycle `eoi_valid` on the next cycle, with `eoi_vector` equal to data bits 7:0. Other sizes, and any write when VERSION is 0x11, give no pulse.
- R11: A pulse on `rirr_set[p]` sets the remote-IRR bit of entry p, and a pulse on `rirr_clr[p]` clears it.
- R12: `route_tbl[64p+63:64p]` always equals entry p as it reads through the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset; only bits 7:0 decoded |
| bus_size | input | 3 | Access size in bytes |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | 32 | Read data |
| eoi_valid | output | 1 | End-of-interrupt vector pulse |
| eoi_vector | output | 8 | End-of-interrupt vector |
| rirr_set | input | PINS | Per-pin remote-IRR set pulses |
| rirr_clr | input | PINS | Per-pin remote-IRR clear pulses |
| dstat | input | PINS | Per-pin delivery status level |
| resvc_req | output | 1 | Service pass request after a table write |
| ctr_clr | output | PINS | One-hot storm counter clear |
| route_tbl | output | PINS*64 | All table entries, entry p at bits 64p+63:64p |

## Verification
The assertions assume that `bus_valid` is a single-cycle strobe sampled on each rising edge, and that `bus_valid` stays low while reset is held. The assertions on remote IRR also assume that `rirr_set` and `rirr_clr` are never pulsed for a pin in the same cycle that software writes that pin. The bench drives one access per two cycles, releases `bus_valid` before the next edge, and keeps its set and clear pulses in separate cycles from any table write to the same pin.

// File: rtl/irr_pkg.sv
package irr_pkg;
   localparam logic [7:0]  OFF_SEL      = 8'h00;
   localparam logic [7:0]  OFF_WIN      = 8'h10;
   localparam logic [7:0]  OFF_EOI      = 8'h40;
   localparam logic [7:0]  SEL_ID       = 8'h00;
   localparam logic [7:0]  SEL_VER      = 8'h01;
   localparam logic [7:0]  SEL_ARB      = 8'h02;
   localparam logic [7:0]  SEL_TBL_BASE = 8'h10;
   localparam logic [2:0]  WORD_SIZE    = 3'd4;
   localparam int          ENTRY_W      = 64;
   localparam int          BIT_DSTAT    = 12;
   localparam int          BIT_RIRR     = 14;
   localparam int          BIT_TRIG     = 15;
   localparam int          BIT_MASK     = 16;
   localparam logic [63:0] ENTRY_RW     = 64'hFFFF_0000_0001_AFFF;
   localparam logic [63:0] ENTRY_RST    = 64'h0000_0000_0001_0000;
endpackage

// File: rtl/irr_decode.sv
module irr_decode
   import irr_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int PINS   = 24,
   localparam int IDX_W = (PINS > 1) ? $clog2(PINS) : 1
) (
   input  logic              bus_valid,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [2:0]        bus_size,
   input  logic [7:0]        sel,
   output logic              acc_sel,
   output logic              acc_win,
   output logic              acc_eoi,
   output logic              tbl_hit,
   output logic [IDX_W-1:0]  tbl_idx,
   output logic              tbl_hi,
   output logic              pick_id,
   output logic              pick_ver
);
   logic [7:0] off;
   logic [7:0] rel;

   assign off      = bus_addr[7:0];
   assign acc_sel  = bus_valid && (off == OFF_SEL);
   assign acc_win  = bus_valid && (off == OFF_WIN) && (bus_size == WORD_SIZE);
   assign acc_eoi  = bus_valid && (off == OFF_EOI) && (bus_size == WORD_SIZE);

   assign rel      = sel - SEL_TBL_BASE;
   assign tbl_hit  = (sel >= SEL_TBL_BASE) && ({1'b0, rel[7:1]} < 8'(PINS));
   assign tbl_idx  = IDX_W'(rel[7:1]);
   assign tbl_hi   = rel[0];
   assign pick_id  = (sel == SEL_ID) || (sel == SEL_ARB);
   assign pick_ver = (sel == SEL_VER);
endmodule

// File: rtl/irr_entry.sv
module irr_entry
   import irr_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_lo,
   input  logic        wr_hi,
   input  logic [31:0] wdata,
   input  logic        rirr_set,
   input  logic        rirr_clr,
   input  logic        dstat,
   output logic [63:0] entry_o
);
   logic [63:0] rw_q, rw_d;
   logic        rirr_q;
   logic        wr_any;

   assign wr_any = wr_lo || wr_hi;

   always_comb begin
      rw_d = rw_q;
      if (wr_lo) rw_d = {rw_q[63:32], wdata} & ENTRY_RW;
      else if (wr_hi) rw_d = {wdata, rw_q[31:0]} & ENTRY_RW;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rw_q   <= ENTRY_RST;
         rirr_q <= 1'b0;
      end else begin
         rw_q <= rw_d;
         if (wr_any && !rw_d[BIT_TRIG]) rirr_q <= 1'b0;
         else if (rirr_set)             rirr_q <= 1'b1;
         else if (rirr_clr)             rirr_q <= 1'b0;
      end
   end

   always_comb begin
      entry_o            = rw_q;
      entry_o[BIT_DSTAT] = dstat;
      entry_o[BIT_RIRR]  = rirr_q;
   end

   // R8: a low-half write with trigger 0 leaves remote IRR clear
   assert_edge_clears_rirr_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lo && !wdata[BIT_TRIG]) |=> !entry_o[BIT_RIRR]);

   // R7: a write that keeps level mode does not touch remote IRR
   assert_level_keeps_rirr_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_any && !rirr_set && !rirr_clr) |=>
      (!entry_o[BIT_TRIG] || (entry_o[BIT_RIRR] == $past(entry_o[BIT_RIRR]))));

   // R11: set pulse without a write raises remote IRR
   assert_set_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (rirr_set && !wr_any) |=> entry_o[BIT_RIRR]);
endmodule

// File: rtl/irr_rdmux.sv
module irr_rdmux
   import irr_pkg::*;
#(
   parameter int          PINS    = 24,
   parameter logic [7:0]  VERSION = 8'h20,
   localparam int         IDX_W   = (PINS > 1) ? $clog2(PINS) : 1
) (
   input  logic [PINS*ENTRY_W-1:0] tbl,
   input  logic                    tbl_hit,
   input  logic [IDX_W-1:0]        tbl_idx,
   input  logic                    tbl_hi,
   input  logic                    pick_id,
   input  logic                    pick_ver,
   input  logic [3:0]              id,
   output logic [31:0]             win_val
);
   localparam logic [31:0] VER_WORD = 32'(VERSION) | (32'(PINS - 1) << 16);
   logic [63:0] ent;

   always_comb begin
      ent = '0;
      for (int p = 0; p < PINS; p++)
         if (tbl_idx == IDX_W'(p)) ent = tbl[p*ENTRY_W +: ENTRY_W];
   end

   always_comb begin
      if (pick_id)       win_val = {4'b0, id, 24'b0};
      else if (pick_ver) win_val = VER_WORD;
      else if (tbl_hit)  win_val = tbl_hi ? ent[63:32] : ent[31:0];
      else               win_val = '0;
   end
endmodule

// File: rtl/intr_route_regs.sv
module intr_route_regs
   import irr_pkg::*;
#(
   parameter int         ADDR_W  = 12,
   parameter int         PINS    = 24,
   parameter logic [7:0] VERSION = 8'h20
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    bus_valid,
   input  logic                    bus_write,
   input  logic [ADDR_W-1:0]       bus_addr,
   input  logic [2:0]              bus_size,
   input  logic [31:0]             bus_wdata,
   output logic                    rd_valid,
   output logic [31:0]             rd_data,
   output logic                    eoi_valid,
   output logic [7:0]              eoi_vector,
   input  logic [PINS-1:0]         rirr_set,
   input  logic [PINS-1:0]         rirr_clr,
   input  logic [PINS-1:0]         dstat,
   output logic                    resvc_req,
   output logic [PINS-1:0]         ctr_clr,
   output logic [PINS*ENTRY_W-1:0] route_tbl
);
   localparam int IDX_W = (PINS > 1) ? $clog2(PINS) : 1;

   if (!(VERSION == 8'h11 || VERSION == 8'h20)) begin : g_bad_version
      $error("intr_route_regs: VERSION must be 8'h11 or 8'h20");
   end
   if (PINS < 1 || PINS > 120) begin : g_bad_pins
      $error("intr_route_regs: PINS must lie in 1..120");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("intr_route_regs: ADDR_W must be at least 8");
   end

   logic [7:0]       sel_q;
   logic [3:0]       id_q;
   logic             acc_sel, acc_win, acc_eoi, tbl_hit, tbl_hi, pick_id, pick_ver;
   logic [IDX_W-1:0] tbl_idx;
   logic [31:0]      win_val;
   logic             tbl_wr;

   irr_decode #(.ADDR_W(ADDR_W), .PINS(PINS)) u_dec (
      .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_size(bus_size),
      .sel(sel_q), .acc_sel(acc_sel), .acc_win(acc_win), .acc_eoi(acc_eoi),
      .tbl_hit(tbl_hit), .tbl_idx(tbl_idx), .tbl_hi(tbl_hi),
      .pick_id(pick_id), .pick_ver(pick_ver));

   assign tbl_wr = acc_win && bus_write && tbl_hit;

   for (genvar p = 0; p < PINS; p++) begin : g_ent
      logic hit_p;
      assign hit_p = tbl_wr && (tbl_idx == IDX_W'(p));
      irr_entry u_ent (
         .clk(clk), .rst_n(rst_n),
         .wr_lo(hit_p && !tbl_hi), .wr_hi(hit_p && tbl_hi),
         .wdata(bus_wdata),
         .rirr_set(rirr_set[p]), .rirr_clr(rirr_clr[p]), .dstat(dstat[p]),
         .entry_o(route_tbl[p*ENTRY_W +: ENTRY_W]));
   end

   irr_rdmux #(.PINS(PINS), .VERSION(VERSION)) u_mux (
      .tbl(route_tbl), .tbl_hit(tbl_hit), .tbl_idx(tbl_idx), .tbl_hi(tbl_hi),
      .pick_id(pick_id), .pick_ver(pick_ver), .id(id_q), .win_val(win_val));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q     <= '0;
         id_q      <= '0;
         rd_valid  <= 1'b0;
         rd_data   <= '0;
         resvc_req <= 1'b0;
         ctr_clr   <= '0;
      end else begin
         rd_valid  <= bus_valid && !bus_write;
         resvc_req <= tbl_wr;
         ctr_clr   <= '0;
         if (tbl_wr) ctr_clr[tbl_idx] <= 1'b1;
         if (acc_sel && bus_write) sel_q <= bus_wdata[7:0];
         if (acc_win && bus_write && (sel_q == SEL_ID)) id_q <= bus_wdata[27:24];
         if (bus_valid && !bus_write)
            rd_data <= acc_sel ? {24'b0, sel_q} : (acc_win ? win_val : 32'b0);
      end
   end

   if (VERSION == 8'h20) begin : g_eoi_on
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            eoi_valid  <= 1'b0;
            eoi_vector <= '0;
         end else begin
            eoi_valid <= acc_eoi && bus_write;
            if (acc_eoi && bus_write) eoi_vector <= bus_wdata[7:0];
         end
      end
   end else begin : g_eoi_off
      assign eoi_valid  = 1'b0;
      assign eoi_vector = '0;
   end

   // R9: counter clear is one-hot and always travels with the service request
   assert_clr_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ctr_clr));
   assert_clr_with_resvc_R9: assert property (@(posedge clk) disable iff (!rst_n)
      resvc_req |-> ($countones(ctr_clr) == 1));
   // R10: every EOI pulse stems from a 4-byte write to the EOI offset
   assert_eoi_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
      eoi_valid |-> $past(bus_valid && bus_write && (bus_addr[7:0] == OFF_EOI)
                          && (bus_size == WORD_SIZE)));
   // R3: read data is flagged only after a read access
   assert_rvalid_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(bus_valid && !bus_write));
   // R5: the identifier moves only on a write
   assert_id_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_valid && bus_write) |=> $stable(id_q));
endmodule

// File: tb/sim_intr_route_regs.sv
module sim_intr_route_regs;
   localparam int CLK_PERIOD = 10;
   localparam int PINS = 24;
   // row: {req[3:0], write, addr[11:0], size[2:0], data[31:0], expect[31:0]}
   localparam int NV = 35;
   localparam logic [83:0] VEC [NV] = '{
      {4'd7, 1'b1, 12'h000, 3'd4, 32'h0000_0010, 32'h0},          // R7 sel entry0 lo
      {4'd7, 1'b1, 12'h010, 3'd4, 32'hFFFF_FFFF, 32'h0},
      {4'd7, 1'b0, 12'h010, 3'd4, 32'h0,         32'h0001_AFFF},  // R7 writable lo
      {4'd6, 1'b1, 12'h000, 3'd4, 32'h0000_0011, 32'h0},          // R6 entry0 hi
      {4'd6, 1'b1, 12'h010, 3'd4, 32'hFFFF_FFFF, 32'h0},
      {4'd6, 1'b0, 12'h010, 3'd4, 32'h0,         32'hFFFF_0000},
      {4'd6, 1'b1, 12'h000, 3'd4, 32'h0000_003F, 32'h0},          // R6 last entry hi
      {4'd6, 1'b1, 12'h010, 3'd4, 32'h1234_5678, 32'h0},
      {4'd6, 1'b0, 12'h010, 3'd4, 32'h0,         32'h1234_0000},
      {4'd6, 1'b1, 12'h000, 3'd4, 32'h0000_0005, 32'h0},          // R6 below table
      {4'd6, 1'b1, 12'h010, 3'd4, 32'hFFFF_FFFF, 32'h0},
      {4'd6, 1'b0, 12'h010, 3'd4, 32'h0,         32'h0},
      {4'd6, 1'b1, 12'h000, 3'd4, 32'h0000_0040, 32'h0},          // R6 above table
      {4'd6, 1'b1, 12'h010, 3'd4, 32'hFFFF_FFFF, 32'h0},
      {4'd6, 1'b0, 12'h010, 3'd4, 32'h0,         32'h0},
      {4'd2, 1'b0, 12'h000, 3'd4, 32'h0,         32'h0000_0040},  // R2 select readback
      {4'd2, 1'b0, 12'h100, 3'd4, 32'h0,         32'h0000_0040},  // R2 alias
      {4'd2, 1'b0, 12'h020, 3'd4, 32'h0,         32'h0},          // R2 unused offset
      {4'd4, 1'b1, 12'h000, 3'd1, 32'h0000_0001, 32'h0},          // R4 version
      {4'd4, 1'b0, 12'h010, 3'd4, 32'h0,         32'h0017_0020},
      {4'd4, 1'b1, 12'h010, 3'd4, 32'hFFFF_FFFF, 32'h0},
      {4'd4, 1'b0, 12'h010, 3'd4, 32'h0,         32'h0017_0020},
      {4'd5, 1'b1, 12'h000, 3'd4, 32'h0000_0000, 32'h0},          // R5 id
      {4'd5, 1'b1, 12'h010, 3'd4, 32'h0A00_0000, 32'h0},
      {4'd5, 1'b0, 12'h010, 3'd4, 32'h0,         32'h0A00_0000},
      {4'd5, 1'b1, 12'h000, 3'd4, 32'h0000_0002, 32'h0},
      {4'd5, 1'b1, 12'h010, 3'd4, 32'h0500_0000, 32'h0},
      {4'd5, 1'b0, 12'h010, 3'd4, 32'h0,         32'h0A00_0000},
      {4'd3, 1'b1, 12'h000, 3'd4, 32'h0000_0012, 32'h0},          // R3 bad size
      {4'd3, 1'b1, 12'h010, 3'd2, 32'h0000_00FF, 32'h0},
      {4'd3, 1'b0, 12'h010, 3'd4, 32'h0,         32'h0001_0000},
      {4'd3, 1'b0, 12'h010, 3'd1, 32'h0,         32'h0},
      {4'd2, 1'b1, 12'h200, 3'd4, 32'h0000_0013, 32'h0},          // R2 alias write
      {4'd2, 1'b0, 12'h000, 3'd4, 32'h0,         32'h0000_0013},
      {4'd6, 1'b0, 12'h010, 3'd4, 32'h0,         32'h0}           // R6 entry1 hi
   };

   logic clk = 0, rst_n = 0;
   logic bus_valid = 0, bus_write = 0;
   logic [11:0] bus_addr = '0;
   logic [2:0] bus_size = '0;
   logic [31:0] bus_wdata = '0;
   logic [PINS-1:0] rirr_set = '0, rirr_clr = '0, dstat = '0;
   logic rd_valid, eoi_valid, resvc_req, rd_valid1, eoi_valid1, resvc1;
   logic [31:0] rd_data, rd_data1;
   logic [7:0] eoi_vector, eoi_vector1;
   logic [PINS-1:0] ctr_clr, ctr_clr1;
   logic [PINS*64-1:0] route_tbl, route_tbl1;

   int n_chk = 0, n_fail = 0;
   logic c_rv, c_eoi, c_eoi1, c_resvc;
   logic [31:0] c_rd;
   logic [7:0] c_vec;
   logic [PINS-1:0] c_clr;

   always #(CLK_PERIOD/2) clk = ~clk;

   intr_route_regs #(.ADDR_W(12), .PINS(PINS), .VERSION(8'h20)) u0 (
      .clk, .rst_n, .bus_valid, .bus_write, .bus_addr, .bus_size, .bus_wdata,
      .rd_valid, .rd_data, .eoi_valid, .eoi_vector, .rirr_set, .rirr_clr,
      .dstat, .resvc_req, .ctr_clr, .route_tbl);

   intr_route_regs #(.ADDR_W(12), .PINS(PINS), .VERSION(8'h11)) u1 (
      .clk, .rst_n, .bus_valid, .bus_write, .bus_addr, .bus_size, .bus_wdata,
      .rd_valid(rd_valid1), .rd_data(rd_data1), .eoi_valid(eoi_valid1),
      .eoi_vector(eoi_vector1), .rirr_set, .rirr_clr, .dstat,
      .resvc_req(resvc1), .ctr_clr(ctr_clr1), .route_tbl(route_tbl1));

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic op(input logic w, input logic [11:0] a, input logic [2:0] s,
                     input logic [31:0] d);
      @(negedge clk);
      bus_valid = 1; bus_write = w; bus_addr = a; bus_size = s; bus_wdata = d;
      @(negedge clk);
      bus_valid = 0;
      c_rv = rd_valid; c_rd = rd_data; c_eoi = eoi_valid; c_vec = eoi_vector;
      c_eoi1 = eoi_valid1; c_resvc = resvc_req; c_clr = ctr_clr;
   endtask

   task automatic pulse(input logic set, input int p);
      @(negedge clk);
      if (set) rirr_set[p] = 1'b1; else rirr_clr[p] = 1'b1;
      @(negedge clk);
      rirr_set = '0; rirr_clr = '0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      op(0, 12'h000, 3'd4, 0); check("R1 select", c_rd, 0);
      check("R3 rd_valid", c_rv, 1);
      op(0, 12'h010, 3'd4, 0); check("R1 id", c_rd, 0);
      for (int p = 0; p < PINS; p++) begin
         op(1, 12'h000, 3'd4, 32'h10 + 2*p);
         op(0, 12'h010, 3'd4, 0); check("R1 entry lo", c_rd, 32'h0001_0000);
         op(1, 12'h000, 3'd4, 32'h11 + 2*p);
         op(0, 12'h010, 3'd4, 0); check("R1 entry hi", c_rd, 0);
      end
      for (int i = 0; i < NV; i++) begin
         op(VEC[i][79], VEC[i][78:67], VEC[i][66:64], VEC[i][63:32]);
         if (!VEC[i][79]) check($sformatf("R%0d row %0d", VEC[i][83:80], i), c_rd, VEC[i][31:0]);
      end
      // R12 parallel table view
      check("R12 entry0", route_tbl[63:0], 64'hFFFF_0000_0001_AFFF);
      check("R12 entry23", route_tbl[23*64 +: 64], 64'h1234_0000_0001_0000);
      // R11 remote IRR set on pin 5
      pulse(1, 5);
      op(1, 12'h000, 3'd4, 32'h1A);
      op(0, 12'h010, 3'd4, 0); check("R11 set", c_rd, 32'h0001_4000);
      check("R9 no pulse on read", {c_resvc, c_clr}, 0);
      op(1, 12'h010, 3'd4, 32'h0000_8031);
      check("R9 resvc", c_resvc, 1); check("R9 clr pin5", c_clr, 24'h20);
      op(0, 12'h010, 3'd4, 0); check("R7 level keeps rirr", c_rd, 32'h0000_C031);
      check("R9 pulse gone", {c_resvc, c_clr}, 0);
      op(1, 12'h010, 3'd4, 32'h0000_5031);
      op(0, 12'h010, 3'd4, 0); check("R8 edge clears rirr", c_rd, 32'h0000_0031);
      dstat[5] = 1'b1;
      op(0, 12'h010, 3'd4, 0); check("R7 dstat shown", c_rd, 32'h0000_1031);
      check("R12 dstat", route_tbl[5*64 +: 32], 32'h0000_1031);
      dstat[5] = 1'b0;
      pulse(1, 5);
      op(1, 12'h010, 3'd4, 32'h0000_8031);
      op(0, 12'h010, 3'd4, 0); check("R11 held", c_rd, 32'h0000_C031);
      pulse(0, 5);
      op(0, 12'h010, 3'd4, 0); check("R11 clear", c_rd, 32'h0000_8031);
      op(1, 12'h000, 3'd4, 32'h10);
      check("R9 no pulse on select", {c_resvc, c_clr}, 0);
      // R10 end of interrupt
      op(1, 12'h040, 3'd4, 32'h0000_01A5);
      check("R10 eoi valid", c_eoi, 1); check("R10 eoi vector", c_vec, 8'hA5);
      check("R10 version 0x11 silent", c_eoi1, 0);
      op(1, 12'h040, 3'd2, 32'h0000_0033);
      check("R10 bad size", c_eoi, 0);
      op(0, 12'h040, 3'd4, 0); check("R2 eoi reads 0", c_rd, 0);
      check("R10 no pulse on read", c_eoi, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule